// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block takes a single input clock and produces two identical output clocks, each as a true/complement pair. A three-bit mode select picks either a straight pass-through of the input or division by 2, 4, 8 or 16. The divided clocks come from a free-running binary counter, so every divided mode has a 50% duty cycle.

An active-low hold input stops the block. While it is low the counter is cleared, every true output sits low and every complement output sits high. When it goes high, a flip-flop clocked on the falling edge of the input clock opens the output gate. The gate therefore only opens while the input clock is low. No shortened first pulse appears in any mode, and the divided sequence always starts again from a zero count. The select pins are expected to idle high, which makes divide-by-16 the mode when they are left undriven.

Top module: `pow2_clock_divider`

## Requirements
- R1: When div_sel[2] is 0, every true output follows clk_in (high while clk_in is high, low while it is low), whatever div_sel[1:0] holds.
- R2: When div_sel[2] is 1, the ratio is 2^(div_sel[1:0]+1): code 2'b00 gives /2, 2'b01 gives /4, 2'b10 gives /8 and 2'b11 gives /16.
- R3: In every divided mode the output stays high for exactly half the ratio in input cycles and low for the other half.
- R4: While hold_n is low, out_p is all zeros, out_n is all ones, and the internal count is held at zero.
- R5: hold_n is taken into an enable register on the falling edge of clk_in. After release no output pulse is shorter than half an input period. Counting the rising edges of clk_in after that falling edge from 1, a divided output first goes high on edge number ratio/2.
- R6: Both pairs carry the same clock, and out_n[i] is always the inverse of out_p[i].
- R7: With the select at its idle value 3'b111, the block divides by 16.
- R8: Each release of hold_n restarts the division from a zero count, whatever state the previous run left behind. The count does not advance while the enable register is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be passed or divided |
| hold_n | input | 1 | Active-low hold: clears the divider and parks the outputs |
| div_sel | input | 3 | Mode select: bit 2 low = pass-through, otherwise bits 1:0 pick /2 to /16 |
| out_p | output | 2 | True clock outputs, one per pair |
| out_n | output | 2 | Complement clock outputs, one per pair |

## Verification
Two functions can act in the same input cycle: releasing the hold and the edges of the selected clock. In pass-through mode the release can land in the very half-cycle where the output would rise. The bench provokes this by raising hold_n just after a rising edge, while clk_in is still high, in every mode. It judges the result two ways. A change monitor on the output flags any interval shorter than half an input period. Each half-cycle sample is also compared with a count that restarts at the first enabled rising edge, and the bench drops hold_n in the middle of a divided high phase to check that the park takes effect immediately.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Divider geometry shared by all sub-blocks.
  localparam int unsigned CNT_W = 4;
  localparam int unsigned TAP_W = $clog2(CNT_W);
  localparam int unsigned SEL_W = TAP_W + 1;

  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_DIV  = 1'b1
  } div_mode_e;
endpackage

// File: rtl/clkdiv_sel_decode.sv
module clkdiv_sel_decode
  import clkdiv_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output div_mode_e        mode,
  output logic [TAP_W-1:0] tap
);
  // Top bit alone decides pass-through; the low bits pick the counter bit.
  always_comb begin
    mode = sel[SEL_W-1] ? MODE_DIV : MODE_PASS;
    tap  = sel[TAP_W-1:0];
  end
endmodule

// File: rtl/clkdiv_enable_reg.sv
module clkdiv_enable_reg (
  input  logic clk_in,
  input  logic hold_n,
  output logic en_q
);
  // Sampled on the falling edge so the gate only moves while clk_in is low.
  always_ff @(negedge clk_in or negedge hold_n) begin
    if (!hold_n) en_q <= 1'b0;
    else         en_q <= 1'b1;
  end

  AST_EN_OPENS: assert property (@(negedge clk_in) disable iff (!hold_n)
    hold_n |=> en_q); // R5
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic             clk_in,
  input  logic             hold_n,
  input  logic             en_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk_in or negedge hold_n) begin
    if (!hold_n)   cnt_q <= '0;
    else if (en_q) cnt_q <= cnt_q + 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk_in) disable iff (!hold_n)
    en_q |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk_in) disable iff (!hold_n)
    !en_q |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2
) (
  input  logic                 clk_in,
  input  logic                 hold_n,
  input  logic                 en_q,
  input  div_mode_e            mode,
  input  logic [TAP_W-1:0]     tap,
  input  logic [CNT_W-1:0]     cnt_q,
  output logic [NUM_PAIRS-1:0] out_p,
  output logic [NUM_PAIRS-1:0] out_n
);
  logic src;

  always_comb begin
    src = (mode == MODE_PASS) ? clk_in : cnt_q[tap];
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    always_comb begin
      out_p[g] = en_q & src;
      out_n[g] = ~(en_q & src);
    end
  end

  AST_PARK_LEVEL: assert property (@(negedge clk_in) disable iff (!hold_n)
    !en_q |-> (out_p == '0 && out_n == '1)); // R4
endmodule

// File: rtl/pow2_clock_divider.sv
module pow2_clock_divider
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2
) (
  input  logic                 clk_in,
  input  logic                 hold_n,
  input  logic [SEL_W-1:0]     div_sel,
  output logic [NUM_PAIRS-1:0] out_p,
  output logic [NUM_PAIRS-1:0] out_n
);
  div_mode_e        mode;
  logic [TAP_W-1:0] tap;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  clkdiv_sel_decode u_dec (
    .sel  (div_sel),
    .mode (mode),
    .tap  (tap)
  );

  clkdiv_enable_reg u_en (
    .clk_in (clk_in),
    .hold_n (hold_n),
    .en_q   (en_q)
  );

  clkdiv_counter u_cnt (
    .clk_in (clk_in),
    .hold_n (hold_n),
    .en_q   (en_q),
    .cnt_q  (cnt_q)
  );

  clkdiv_out_stage #(.NUM_PAIRS(NUM_PAIRS)) u_out (
    .clk_in (clk_in),
    .hold_n (hold_n),
    .en_q   (en_q),
    .mode   (mode),
    .tap    (tap),
    .cnt_q  (cnt_q),
    .out_p  (out_p),
    .out_n  (out_n)
  );
endmodule

// File: tb/pow2_clock_divider_tb_top.sv
`timescale 1ns/1ps
module pow2_clock_divider_tb_top;
  logic       clk_in = 1'b0;
  logic       hold_n = 1'b0;
  logic [2:0] div_sel = 3'b111; // idle-high select pins (R7)
  logic [1:0] out_p, out_n;

  int  checks = 0;
  int  errors = 0;
  int  runts  = 0;
  bit  watch  = 0;
  bit  done   = 0;
  realtime last_chg = 0.0;

  always #5 clk_in = ~clk_in;

  pow2_clock_divider dut_i (
    .clk_in (clk_in),
    .hold_n (hold_n),
    .div_sel(div_sel),
    .out_p  (out_p),
    .out_n  (out_n)
  );

  // Any change of the first true output closer than half an input period is a runt.
  always @(out_p[0]) begin
    if (watch && ($realtime - last_chg < 4.5)) runts++;
    last_chg = $realtime;
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pair_val(input logic p);
    return {p, p, ~p, ~p};
  endfunction

  // Release in the high half of clk_in, then follow each half-cycle.
  task automatic run_mode(input logic [2:0] code, input string tag);
    int  sh;
    logic e;
    hold_n  = 1'b0;
    div_sel = code;
    @(posedge clk_in); #1;
    chk("R4 park high-phase", {out_p, out_n}, pair_val(1'b0));
    @(negedge clk_in); #1;
    chk("R4 park low-phase", {out_p, out_n}, pair_val(1'b0));
    @(posedge clk_in); #1;
    watch = 1; last_chg = $realtime; runts = 0;
    hold_n = 1'b1;
    #0.5;
    chk("R5 no release in high phase", {out_p, out_n}, pair_val(1'b0));
    @(negedge clk_in); #1;
    chk("R5 first enabled low phase", {out_p, out_n}, pair_val(1'b0));
    sh = int'(code[1:0]);
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk_in); #1;
      e = code[2] ? logic'((i >> sh) & 1) : 1'b1;
      chk(tag, {out_p, out_n}, pair_val(e));
      @(negedge clk_in); #1;
      e = code[2] ? logic'((i >> sh) & 1) : 1'b0;
      chk(tag, {out_p, out_n}, pair_val(e));
    end
    watch = 0;
    chk("R5 runt count", 4'(runts), 4'd0);
  endtask

  // Drop hold in the middle of a divided high phase: park must be immediate.
  task automatic mid_run_hold();
    run_mode(3'b101, "R2,R3,R6 /4 before hold");
    @(posedge clk_in); #1; // count 41 -> bit1 = 0, then 42 -> bit1 = 1
    @(posedge clk_in); #1;
    chk("R2 /4 high before hold", {out_p, out_n}, pair_val(1'b1));
    hold_n = 1'b0;
    #1;
    chk("R4 park on hold assertion", {out_p, out_n}, pair_val(1'b0));
    repeat (3) @(posedge clk_in);
    #1;
    chk("R8 held while parked", {out_p, out_n}, pair_val(1'b0));
  endtask

  initial begin
    #1;
    chk("R4 reset state", {out_p, out_n}, pair_val(1'b0));
    // R7: idle select value, never driven otherwise first.
    run_mode(div_sel, "R7 idle select /16");
    for (int c = 0; c < 8; c++) begin
      if (c < 4) run_mode(3'(c), "R1,R6 pass-through");
      else       run_mode(3'(c), "R2,R3,R6 divided");
    end
    mid_run_hold();
    // R8: restart after a run that left a nonzero count.
    run_mode(3'b110, "R8 restart /8");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule